// File: doc/BRIEF.md
# Integer-N Synthesizer Divider and Phase Comparator

This block is the digital heart of an integer-N frequency synthesizer. Two strobe inputs, each one system-clock cycle wide, mark the edges of the crystal reference and of the already prescaled oscillator feedback. The reference strobes pass through a programmable divider (8-bit ratio) and then a fixed divide-by-2 stage. The feedback strobes pass through a programmable 12-bit divider. The two resulting comparison events drive a three-state phase/frequency comparator, whose UP and DOWN outputs steer an external charge pump.

Each divider clamps its ratio to the legal window and takes a new ratio only when a period ends, so a period is never cut short. Both divided rates are brought out as level signals for observation. The charge pump, the oscillator and the loop filter lie outside the block.

Top module: `synth_pfd_core`

## Requirements
- R1: After reset `up_o`, `dn_o`, `ref_clk_o` and `fb_clk_o` are all 0.
- R2: `ref_clk_o` inverts once for every N strobes on `ref_stb_i`, where N is the reference ratio taken as an unsigned 8-bit value. The first period after reset uses the ratio present at the first strobe.
- R3: A reference ratio below 2 acts as 2, and one above 80 acts as 80.
- R4: `fb_clk_o` inverts once for every M strobes on `fb_stb_i`, where M is the feedback ratio taken as an unsigned 12-bit value.
- R5: A feedback ratio below 128 acts as 128, and one above 2600 acts as 2600.
- R6: Each divider samples its ratio input only at the strobe that completes a period. That value sets the length of the next period. The period in progress keeps its length, and a change that is reverted before the period completes has no effect.
- R7: A reference comparison event occurs on every second reference-divider period, that is once per 2N reference strobes. At N=2, three strobes produce neither UP nor DOWN.
- R8: UP rises two clock cycles after the reference strobe that completes a comparison period. DOWN rises one clock cycle after the feedback strobe that completes a feedback period.
- R9: Once UP and DOWN are both high, both stay high for exactly RST_DLY cycles (2 by default) and then both clear. A lead of d cycles by one side therefore gives that side a pulse of d+RST_DLY cycles, while the other side's pulse lasts RST_DLY cycles.
- R10: UP and DOWN each fall only in a cycle that follows one in which both were high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_stb_i | input | 1 | One-cycle strobe per crystal reference edge |
| fb_stb_i | input | 1 | One-cycle strobe per prescaled feedback edge |
| ref_ratio_i | input | 8 | Requested reference divide ratio |
| fb_ratio_i | input | 12 | Requested feedback divide ratio |
| up_o | output | 1 | Charge-pump pump-up request |
| dn_o | output | 1 | Charge-pump pump-down request |
| ref_clk_o | output | 1 | Level that inverts on each reference-divider period |
| fb_clk_o | output | 1 | Level that inverts on each feedback-divider period |

## Verification
The hardest case to reach from the ports is an exact overlap of UP and DOWN with a known lead. The stimulus has to land the final strobe of both dividers on chosen cycles. To get there, the bench counts every strobe: it delivers all but the last strobe of each comparison period, pauses, and then places the two closing strobes on cycles a fixed distance apart (ahead, equal and behind). The second hard case is a ratio edit made in the middle of a period, with and without a revert before the period closes. The bench reaches it by changing the ratio input between strobes whose positions in the period are known.

// File: rtl/synth_pfd_pkg.sv
package synth_pfd_pkg;

    // Default widths and legal ratio windows
    localparam int REF_RATIO_W   = 8;
    localparam int REF_RATIO_MIN = 2;
    localparam int REF_RATIO_MAX = 80;
    localparam int FB_RATIO_W    = 12;
    localparam int FB_RATIO_MIN  = 128;
    localparam int FB_RATIO_MAX  = 2600;
    localparam int POST_DIV_DEF  = 2;
    localparam int OVERLAP_DEF   = 2;

    // Comparator state: bit 1 is the UP flag, bit 0 is the DOWN flag
    typedef enum logic [1:0] {
        CMP_IDLE = 2'b00,
        CMP_DN   = 2'b01,
        CMP_UP   = 2'b10,
        CMP_BOTH = 2'b11
    } cmp_state_e;

endpackage

// File: rtl/prog_ratio_div.sv
module prog_ratio_div #(
    parameter int W     = 8,
    parameter int R_MIN = 2,
    parameter int R_MAX = 80
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stb_i,
    input  logic [W-1:0] ratio_i,
    output logic         tc_o,
    output logic         lvl_o
);

    localparam logic [W-1:0] LO = W'(R_MIN);
    localparam logic [W-1:0] HI = W'(R_MAX);

    typedef struct packed {
        logic [W-1:0] cnt;    // strobes seen in the current period
        logic [W-1:0] ratio;  // ratio of the current period
        logic         valid;  // a ratio has been captured since reset
        logic         tc;     // terminal-count pulse
        logic         lvl;    // observation level
    } div_st_t;

    div_st_t st_d, st_q;
    logic [W-1:0] clamped;
    logic [W-1:0] eff_ratio;
    logic [W:0]   cnt_inc;

    always_comb begin
        if (ratio_i < LO)
            clamped = LO;
        else if (ratio_i > HI)
            clamped = HI;
        else
            clamped = ratio_i;

        eff_ratio = st_q.valid ? st_q.ratio : clamped;
        cnt_inc   = {1'b0, st_q.cnt} + {{W{1'b0}}, 1'b1};

        st_d    = st_q;
        st_d.tc = 1'b0;
        if (stb_i) begin
            st_d.valid = 1'b1;
            if (!st_q.valid)
                st_d.ratio = clamped;
            if (cnt_inc == {1'b0, eff_ratio}) begin
                st_d.cnt   = '0;
                st_d.tc    = 1'b1;
                st_d.lvl   = ~st_q.lvl;
                st_d.ratio = clamped;   // next period length latched here only
            end else begin
                st_d.cnt = cnt_inc[W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign tc_o  = st_q.tc;
    assign lvl_o = st_q.lvl;

endmodule

// File: rtl/post_div.sv
module post_div #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_tc_i,
    output logic tc_o
);

    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tc;
    } post_st_t;

    post_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.tc = 1'b0;
        if (in_tc_i) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt = '0;
                st_d.tc  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign tc_o = st_q.tc;

endmodule

// File: rtl/phase_freq_det.sv
module phase_freq_det
    import synth_pfd_pkg::*;
#(
    parameter int RST_DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_ev_i,
    input  logic fb_ev_i,
    output logic up_o,
    output logic dn_o
);

    localparam int DW = (RST_DLY > 1) ? $clog2(RST_DLY + 1) : 1;
    localparam logic [DW-1:0] DLY_LAST = DW'(RST_DLY - 1);

    typedef struct packed {
        cmp_state_e    st;
        logic [DW-1:0] dly;
    } pfd_st_t;

    pfd_st_t st_d, st_q;
    logic up_cur, dn_cur, both, clr, up_n, dn_n;

    always_comb begin
        up_cur = (st_q.st == CMP_UP) || (st_q.st == CMP_BOTH);
        dn_cur = (st_q.st == CMP_DN) || (st_q.st == CMP_BOTH);
        both   = (st_q.st == CMP_BOTH);
        clr    = both && (st_q.dly == DLY_LAST);

        // A fresh event sets its flag even in the clearing cycle
        up_n = (up_cur && !clr) || ref_ev_i;
        dn_n = (dn_cur && !clr) || fb_ev_i;

        st_d.st  = cmp_state_e'({up_n, dn_n});
        st_d.dly = (both && !clr) ? st_q.dly + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.st  <= CMP_IDLE;
            st_q.dly <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign up_o = (st_q.st == CMP_UP) || (st_q.st == CMP_BOTH);
    assign dn_o = (st_q.st == CMP_DN) || (st_q.st == CMP_BOTH);

endmodule

// File: rtl/synth_pfd_core.sv
module synth_pfd_core
    import synth_pfd_pkg::*;
#(
    parameter int REF_W    = REF_RATIO_W,
    parameter int REF_MIN  = REF_RATIO_MIN,
    parameter int REF_MAX  = REF_RATIO_MAX,
    parameter int FB_W     = FB_RATIO_W,
    parameter int FB_MIN   = FB_RATIO_MIN,
    parameter int FB_MAX   = FB_RATIO_MAX,
    parameter int POST_DIV = POST_DIV_DEF,
    parameter int RST_DLY  = OVERLAP_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_stb_i,
    input  logic             fb_stb_i,
    input  logic [REF_W-1:0] ref_ratio_i,
    input  logic [FB_W-1:0]  fb_ratio_i,
    output logic             up_o,
    output logic             dn_o,
    output logic             ref_clk_o,
    output logic             fb_clk_o
);

    logic ref_tc;   // reference divider terminal count
    logic ref_ev;   // reference comparison event after fixed divide
    logic fb_ev;    // feedback comparison event

    prog_ratio_div #(
        .W     (REF_W),
        .R_MIN (REF_MIN),
        .R_MAX (REF_MAX)
    ) u_ref_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb_i   (ref_stb_i),
        .ratio_i (ref_ratio_i),
        .tc_o    (ref_tc),
        .lvl_o   (ref_clk_o)
    );

    post_div #(
        .DIV (POST_DIV)
    ) u_ref_post (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_tc_i (ref_tc),
        .tc_o    (ref_ev)
    );

    prog_ratio_div #(
        .W     (FB_W),
        .R_MIN (FB_MIN),
        .R_MAX (FB_MAX)
    ) u_fb_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb_i   (fb_stb_i),
        .ratio_i (fb_ratio_i),
        .tc_o    (fb_ev),
        .lvl_o   (fb_clk_o)
    );

    phase_freq_det #(
        .RST_DLY (RST_DLY)
    ) u_pfd (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_ev_i (ref_ev),
        .fb_ev_i  (fb_ev),
        .up_o     (up_o),
        .dn_o     (dn_o)
    );

endmodule

// File: rtl/synth_pfd_core_chk.sv
module synth_pfd_core_chk #(
    parameter int RST_DLY = 2
) (
    input logic clk,
    input logic rst_n,
    input logic ref_tc,
    input logic ref_ev,
    input logic fb_ev,
    input logic up_o,
    input logic dn_o
);

    logic [7:0] both_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            both_cnt_q <= '0;
        else if (up_o && dn_o)
            both_cnt_q <= (both_cnt_q == 8'hff) ? both_cnt_q : both_cnt_q + 8'd1;
        else
            both_cnt_q <= '0;
    end

    assert_up_after_ref_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ev |=> up_o);

    assert_dn_after_fb_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fb_ev |=> dn_o);

    assert_overlap_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (up_o && dn_o) |-> (both_cnt_q < 8'(RST_DLY)));

    assert_up_falls_after_both_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(up_o) |-> $past(dn_o));

    assert_dn_falls_after_both_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dn_o) |-> $past(up_o));

    assert_ref_event_from_tc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ev |-> $past(ref_tc));

    assert_ref_event_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ev |=> !ref_ev);

endmodule

bind synth_pfd_core synth_pfd_core_chk #(.RST_DLY(RST_DLY)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ref_tc (ref_tc),
    .ref_ev (ref_ev),
    .fb_ev  (fb_ev),
    .up_o   (up_o),
    .dn_o   (dn_o)
);

// File: tb/synth_pfd_core_bench.sv
`timescale 1ns/1ps
module synth_pfd_core_bench;

    localparam int OVL = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_stb = 1'b0;
    logic        fb_stb = 1'b0;
    logic [7:0]  ref_ratio = 8'd5;
    logic [11:0] fb_ratio = 12'd130;
    logic        up, dn, refc, fbc;

    int tests = 0;
    int fails = 0;
    bit per_en = 1'b0;
    bit pfd_en = 1'b0;
    bit done = 1'b0;

    int exp_ref[$];
    int exp_fb[$];
    int exp_up[$];
    int exp_dn[$];

    always #2 clk = ~clk;

    synth_pfd_core u_synth_pfd_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_stb_i   (ref_stb),
        .fb_stb_i    (fb_stb),
        .ref_ratio_i (ref_ratio),
        .fb_ratio_i  (fb_ratio),
        .up_o        (up),
        .dn_o        (dn),
        .ref_clk_o   (refc),
        .fb_clk_o    (fbc)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: samples one time unit after each rising edge
    int   ref_cnt, fb_cnt, up_run, dn_run;
    logic ref_prev, fb_prev;

    always @(posedge clk) begin
        #1;
        if (!rst_n) begin
            ref_cnt = 0; fb_cnt = 0; up_run = 0; dn_run = 0;
            ref_prev = refc; fb_prev = fbc;
        end else begin
            if (ref_stb) ref_cnt++;
            if (fb_stb)  fb_cnt++;
            if (refc !== ref_prev) begin
                if (per_en) begin
                    if (exp_ref.size() == 0) check(1'b0, "R2 unexpected ref level change", ref_cnt, -1);
                    else begin
                        int e;
                        e = exp_ref.pop_front();
                        check(ref_cnt == e, "R2/R3/R6 ref period length", ref_cnt, e);
                    end
                end
                ref_cnt = 0;
                ref_prev = refc;
            end
            if (fbc !== fb_prev) begin
                if (per_en) begin
                    if (exp_fb.size() == 0) check(1'b0, "R4 unexpected fb level change", fb_cnt, -1);
                    else begin
                        int e;
                        e = exp_fb.pop_front();
                        check(fb_cnt == e, "R4/R5/R6 fb period length", fb_cnt, e);
                    end
                end
                fb_cnt = 0;
                fb_prev = fbc;
            end
            if (pfd_en) begin
                if (up) up_run++;
                else if (up_run > 0) begin
                    if (exp_up.size() == 0) check(1'b0, "R9 unexpected UP pulse", up_run, -1);
                    else begin
                        int e;
                        e = exp_up.pop_front();
                        check(up_run == e, "R9/R10 UP pulse width", up_run, e);
                    end
                    up_run = 0;
                end
                if (dn) dn_run++;
                else if (dn_run > 0) begin
                    if (exp_dn.size() == 0) check(1'b0, "R9 unexpected DOWN pulse", dn_run, -1);
                    else begin
                        int e;
                        e = exp_dn.pop_front();
                        check(dn_run == e, "R9/R10 DOWN pulse width", dn_run, e);
                    end
                    dn_run = 0;
                end
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_ref(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ref_stb = 1'b1;
            @(negedge clk) ref_stb = 1'b0;
        end
    endtask

    task automatic pulse_fb(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) fb_stb = 1'b1;
            @(negedge clk) fb_stb = 1'b0;
        end
    endtask

    // One comparison period at ref ratio 2 and fb ratio 128, closing strobes lag apart
    task automatic run_cycle(input int lag);
        int d;
        int ta;
        int tb;
        pulse_ref(3);
        pulse_fb(127);
        repeat (3) @(negedge clk);
        check(!up && !dn, "R7 no event after 3 ref strobes at ratio 2", {up, dn}, 0);
        d  = lag - 1;
        exp_up.push_back(((d > 0) ? d : 0) + OVL);
        exp_dn.push_back(((d < 0) ? -d : 0) + OVL);
        ta = 10;
        tb = 10 + lag;
        for (int t = 0; t < 40; t++) begin
            @(negedge clk);
            if (lag == 6) begin
                if (t == 12) check(up == 1'b0, "R8 UP still low one cycle after closing strobe", up, 0);
                if (t == 13) check(up == 1'b1, "R8 UP high two cycles after closing strobe", up, 1);
                if (t == 17) check(dn == 1'b0, "R8 DOWN low at closing strobe edge", dn, 0);
                if (t == 18) check(dn == 1'b1, "R8 DOWN high one cycle after closing strobe", dn, 1);
            end
            ref_stb = (t == ta);
            fb_stb  = (t == tb);
        end
        ref_stb = 1'b0;
        fb_stb  = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #400000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        // Section 1: divider periods, clamps and ratio update timing
        ref_ratio = 8'd5;
        fb_ratio  = 12'd130;
        do_reset();
        check(up == 1'b0,   "R1 UP after reset", up, 0);
        check(dn == 1'b0,   "R1 DOWN after reset", dn, 0);
        check(refc == 1'b0, "R1 ref level after reset", refc, 0);
        check(fbc == 1'b0,  "R1 fb level after reset", fbc, 0);
        per_en = 1'b1;

        // R2 plain periods
        exp_ref.push_back(5); exp_ref.push_back(5);
        pulse_ref(10);
        // R6 change mid period: current keeps 5, next is 7
        exp_ref.push_back(5);
        pulse_ref(2);
        ref_ratio = 8'd7;
        pulse_ref(3);
        exp_ref.push_back(7);
        pulse_ref(7);
        // R6 change reverted before the period closes
        exp_ref.push_back(7);
        pulse_ref(3);
        ref_ratio = 8'd3;
        pulse_ref(1);
        ref_ratio = 8'd7;
        pulse_ref(3);
        exp_ref.push_back(7);
        pulse_ref(7);
        // R3 low clamp: 0 acts as 2
        ref_ratio = 8'd0;
        exp_ref.push_back(7);
        pulse_ref(7);
        exp_ref.push_back(2); exp_ref.push_back(2);
        pulse_ref(4);
        // R3 high clamp: 200 acts as 80
        ref_ratio = 8'd200;
        exp_ref.push_back(2);
        pulse_ref(2);
        exp_ref.push_back(80);
        pulse_ref(80);

        // R4 plain period, R5 clamps
        exp_fb.push_back(130);
        pulse_fb(130);
        fb_ratio = 12'd5;
        exp_fb.push_back(130);
        pulse_fb(130);
        exp_fb.push_back(128);
        pulse_fb(128);
        fb_ratio = 12'd4095;
        exp_fb.push_back(128);
        pulse_fb(128);
        exp_fb.push_back(2600);
        pulse_fb(2600);

        repeat (10) @(negedge clk);
        check(exp_ref.size() == 0, "R2 all ref periods observed", exp_ref.size(), 0);
        check(exp_fb.size() == 0,  "R4 all fb periods observed", exp_fb.size(), 0);
        per_en = 1'b0;

        // Section 2: comparator behaviour
        ref_ratio = 8'd2;
        fb_ratio  = 12'd128;
        do_reset();
        pfd_en = 1'b1;
        run_cycle(6);    // reference leads by 5 cycles
        run_cycle(1);    // coincident events
        run_cycle(-3);   // feedback leads by 4 cycles
        run_cycle(2);    // reference leads by 1 cycle
        repeat (10) @(negedge clk);
        check(exp_up.size() == 0, "R9 all UP pulses observed", exp_up.size(), 0);
        check(exp_dn.size() == 0, "R10 all DOWN pulses observed", exp_dn.size(), 0);
        pfd_en = 1'b0;

        done = 1'b1;
        finish_run();
    end

endmodule